// File: doc/BRIEF.md
# Table-Driven Programmable Clock Divider

This block produces a slower clock from a fast source clock. The division ratio comes from a small select field combined with a two-bit table choice, and the decoded ratio is always even. The output therefore has a 50% duty cycle: it spends ratio/2 source cycles high and ratio/2 cycles low. A single-cycle strobe marks every rising edge of the divided clock, so logic in the source domain can act on it without edge detection.

The ratio in force is latched only when the divided output rises, and once more while reset is held. A select or table change made mid-period lets the running period finish at the old ratio, so the output never produces a runt pulse.

Each instance takes its select field from a register field. The field is usually three bits wide, though one user connects a two-bit field; the parameter `SEL_W` covers both cases and zero-extends the narrow field.

Top module: `clkdiv_table`

## Requirements
- R1: With table code 0, a select value s gives a ratio of 2·(s+1), covering 2 to 16.
- R2: With table code 1, a select value s gives a ratio of 4·(s+1), covering 4 to 32.
- R3: With table code 2, select values 0 and 1 both give a ratio of 4, and select values 2 to 7 give 2·(s+1).
- R4: Table code 3 decodes exactly like table code 0.
- R5: In every period the divided clock is high for ratio/2 source cycles and low for ratio/2 source cycles.
- R6: While reset (`rst_n` low) is held, `clk_div` and `div_strobe` are low and the ratio is taken from the inputs. The first rising edge of `clk_div` comes at the ratio/2-th source rising edge after reset is released.
- R7: `div_strobe` is high for exactly one source cycle at each rising edge of `clk_div`, namely the first cycle in which `clk_div` is high.
- R8: A change of `ratio_sel` or `table_sel` does not alter the period in progress. The new ratio applies from the next rising edge of `clk_div`.
- R9: With `SEL_W` = 2, the select field is zero-extended to three bits before decoding. For example, table code 1 with select 3 gives a ratio of 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| table_sel | input | 2 | Decode table choice (0, 1, 2; 3 acts as 0) |
| ratio_sel | input | SEL_W | Select field taken from a clock-selection register |
| clk_div | output | 1 | Divided clock, 50% duty |
| div_strobe | output | 1 | One-cycle pulse at each rising edge of clk_div |

## Verification
After reset is released, the first rise of `clk_div` and the matching `div_strobe` pulse are due at the ratio/2-th source rising edge. Each later period is due `ratio` edges after the previous strobe. The bench drives inputs and samples outputs on the falling edge, so it counts the whole number of cycles between strobes and the high cycles within each period. A configuration change is applied in the strobe cycle itself. The period then under way is checked against the old ratio and the following period against the new one.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // Decode table choice carried on table_sel
  typedef enum logic [1:0] {
    TBL_STEP2  = 2'd0,
    TBL_STEP4  = 2'd1,
    TBL_FLOOR4 = 2'd2,
    TBL_ALIAS  = 2'd3
  } tbl_e;

  localparam int unsigned FULL_SEL_W = 3;

  // Even division ratio for a table choice and a full-width select value
  function automatic int unsigned ratio_of(input tbl_e tbl, input logic [FULL_SEL_W-1:0] sel);
    int unsigned step;
    step = int'(sel) + 1;
    case (tbl)
      TBL_STEP4:  ratio_of = step * 4;
      TBL_FLOOR4: ratio_of = (sel < 3'd2) ? 4 : step * 2;
      default:    ratio_of = step * 2;
    endcase
  endfunction

endpackage

// File: rtl/clkdiv_decode.sv
module clkdiv_decode
  import clkdiv_pkg::*;
#(
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned HALF_W = 5
) (
  input  logic [1:0]        table_sel,
  input  logic [SEL_W-1:0]  ratio_sel,
  output logic [HALF_W-1:0] half_ratio
);

  logic [FULL_SEL_W-1:0] sel_full;
  int unsigned           ratio_w;

  generate
    if (SEL_W < FULL_SEL_W) begin : g_narrow
      assign sel_full = {{(FULL_SEL_W-SEL_W){1'b0}}, ratio_sel};
    end else begin : g_full
      assign sel_full = ratio_sel[FULL_SEL_W-1:0];
    end
  endgenerate

  always_comb begin
    ratio_w    = ratio_of(tbl_e'(table_sel), sel_full);
    half_ratio = HALF_W'(ratio_w >> 1);
  end

  // Decoded ratio stays inside the widest table range and is even
  always_comb begin
    if (!$isunknown({table_sel, ratio_sel})) begin
      assert_ratio_range_R1: assert (ratio_w >= 2 && ratio_w <= 32);
      assert_ratio_even_R5:  assert (ratio_w[0] == 1'b0);
    end
  end

endmodule

// File: rtl/clkdiv_phase.sv
module clkdiv_phase #(
  parameter int unsigned HALF_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] next_half,
  output logic              div_q,
  output logic              strobe_q
);

  logic [HALF_W-1:0] cnt_q;
  logic [HALF_W-1:0] half_q;
  logic              seen_q;
  logic              phase_end;
  logic              rise_evt;

  assign phase_end = (cnt_q == half_q - HALF_W'(1));
  assign rise_evt  = phase_end && !div_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      div_q    <= 1'b0;
      strobe_q <= 1'b0;
      half_q   <= next_half;
      seen_q   <= 1'b0;
    end else begin
      seen_q   <= 1'b1;
      strobe_q <= rise_evt;
      if (phase_end) begin
        cnt_q <= '0;
        div_q <= !div_q;
        if (rise_evt) half_q <= next_half;
      end else begin
        cnt_q <= cnt_q + HALF_W'(1);
      end
    end
  end

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> (cnt_q < half_q));

  assert_toggle_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && (div_q != $past(div_q)) |-> ($past(cnt_q) == $past(half_q) - HALF_W'(1)));

  assert_strobe_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && $rose(div_q) |-> strobe_q);

  assert_strobe_means_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && strobe_q |-> (div_q && !$past(div_q)));

  assert_ratio_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && !strobe_q |-> $stable(half_q));

endmodule

// File: rtl/clkdiv_table.sv
module clkdiv_table #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk_src,
  input  logic             rst_n,
  input  logic [1:0]       table_sel,
  input  logic [SEL_W-1:0] ratio_sel,
  output logic             clk_div,
  output logic             div_strobe
);

  localparam int unsigned MAX_HALF = 2 ** (SEL_W + 1);
  localparam int unsigned HALF_W   = $clog2(MAX_HALF + 1);

  logic [HALF_W-1:0] half_ratio;

  clkdiv_decode #(
    .SEL_W  (SEL_W),
    .HALF_W (HALF_W)
  ) u_decode (
    .table_sel  (table_sel),
    .ratio_sel  (ratio_sel),
    .half_ratio (half_ratio)
  );

  clkdiv_phase #(
    .HALF_W (HALF_W)
  ) u_phase (
    .clk       (clk_src),
    .rst_n     (rst_n),
    .next_half (half_ratio),
    .div_q     (clk_div),
    .strobe_q  (div_strobe)
  );

  assert_reset_low_R6: assert property (@(posedge clk_src)
    !rst_n |=> (!clk_div && !div_strobe));

endmodule

// File: tb/clkdiv_table_bench.sv
module clkdiv_table_bench;

  logic       clk_src = 1'b0;
  logic       rst_n   = 1'b0;
  logic [1:0] table_sel = 2'd0;
  logic [2:0] ratio_sel = 3'd0;
  logic [1:0] ratio_sel2 = 2'd0;
  logic       clk_div, div_strobe, clk_div2, div_strobe2;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk_src = !clk_src;

  clkdiv_table #(.SEL_W(3)) u_clkdiv_table (
    .clk_src(clk_src), .rst_n(rst_n), .table_sel(table_sel), .ratio_sel(ratio_sel),
    .clk_div(clk_div), .div_strobe(div_strobe));

  clkdiv_table #(.SEL_W(2)) u_narrow (
    .clk_src(clk_src), .rst_n(rst_n), .table_sel(table_sel), .ratio_sel(ratio_sel2),
    .clk_div(clk_div2), .div_strobe(div_strobe2));

  function automatic int expect_ratio(input int tbl, input int s);
    if (tbl == 1) return 4 * s + 4;
    if (tbl == 2 && s < 2) return 4;
    return 2 * s + 2;
  endfunction

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic logic pick_div(input bit nar);
    return nar ? clk_div2 : clk_div;
  endfunction

  function automatic logic pick_stb(input bit nar);
    return nar ? div_strobe2 : div_strobe;
  endfunction

  task automatic sync_strobe(input bit nar);
    int guard = 0;
    do begin
      @(negedge clk_src);
      guard++;
    end while (!pick_stb(nar) && guard < 200);
  endtask

  // Starts in a strobe cycle, ends in the next strobe cycle
  task automatic measure(input bit nar, input int exp, input string tag);
    int n = 0;
    int h = 0;
    int guard = 0;
    forever begin
      if (pick_div(nar)) h++;
      n++;
      @(negedge clk_src);
      guard++;
      if (pick_stb(nar) || guard > 200) break;
    end
    check({tag, " period"}, n, exp);
    check({"R5 high time ", tag}, h, exp / 2);
  endtask

  task automatic test_reset(input int tbl, input int s);
    int k = 0;
    @(negedge clk_src);
    rst_n = 1'b0;
    table_sel = 2'(tbl);
    ratio_sel = 3'(s);
    repeat (3) @(negedge clk_src);
    check("R6 clk_div low in reset", int'(clk_div), 0);
    check("R6 strobe low in reset", int'(div_strobe), 0);
    rst_n = 1'b1;
    do begin
      @(negedge clk_src);
      k++;
    end while (!clk_div && k < 100);
    check("R6 first rise delay", k, expect_ratio(tbl, s) / 2);
    check("R7 strobe with first rise", int'(div_strobe), 1);
    @(negedge clk_src);
    check("R7 strobe one cycle", int'(div_strobe), 0);
  endtask

  task automatic test_table(input int tbl);
    string tag;
    for (int s = 0; s < 8; s++) begin
      sync_strobe(1'b0);
      table_sel = 2'(tbl);
      ratio_sel = 3'(s);
      sync_strobe(1'b0);
      tag = (tbl == 0) ? "R1" : (tbl == 1) ? "R2" : (tbl == 2) ? "R3" : "R4";
      measure(1'b0, expect_ratio(tbl, s), $sformatf("%s table %0d sel %0d", tag, tbl, s));
    end
  endtask

  task automatic test_change(input int t0, input int s0, input int t1, input int s1);
    sync_strobe(1'b0);
    table_sel = 2'(t0);
    ratio_sel = 3'(s0);
    sync_strobe(1'b0);
    table_sel = 2'(t1);
    ratio_sel = 3'(s1);
    measure(1'b0, expect_ratio(t0, s0), "R8 old ratio kept");
    measure(1'b0, expect_ratio(t1, s1), "R8 new ratio applied");
  endtask

  task automatic test_narrow();
    for (int s = 0; s < 4; s++) begin
      sync_strobe(1'b1);
      table_sel = 2'd1;
      ratio_sel2 = 2'(s);
      sync_strobe(1'b1);
      measure(1'b1, expect_ratio(1, s), $sformatf("R9 narrow sel %0d", s));
    end
  endtask

  initial begin
    test_reset(0, 0);
    test_reset(1, 7);
    test_reset(2, 1);
    test_table(0);
    test_table(1);
    test_table(2);
    test_table(3);
    test_change(1, 7, 0, 0);
    test_change(0, 0, 2, 5);
    test_change(2, 0, 2, 1);
    test_narrow();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk_src) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: cycles actual=%0d expected<=150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule